// File: doc/BRIEF.md
# Tagged-Set Streaming Summation Unit

This unit takes a stream of integer values, one per cycle at most, over a valid/ready handshake. Every value carries a set identifier and a flag that marks the final element of its set. The unit adds together all values of a set and emits one total per set, together with that set's identifier. The elements of a set arrive back to back in the stream, although idle cycles may fall between them. A new set may start while earlier sets are still being reduced.

All additions go through one pipelined adder of parameterised latency. Because a sum leaves the adder several cycles after its operands enter, the unit cannot simply feed each result back. Instead, a scheduler picks the adder's two operands every cycle. It draws on the incoming value, a small pool of buffered values and the result leaving the adder, and it pairs only operands that belong to the same set. Each open set holds one internal tracking slot. The slot counts the live operands of its set, so the unit can tell when a set has been reduced to a single total. Totals are released from these slots in the order the sets arrived.

Top module: `streamsum_reducer`

## Requirements
- R1: For every set, the unit emits one total equal to the sum of all the set's values modulo 2^DATA_W, with out_id_o equal to the identifier carried by the set's first element.
- R2: A set made of one element (its first accepted element has in_last_i high) produces a total equal to that element's value, unchanged.
- R3: Totals leave in the order in which the sets' first elements were accepted, even when a later set finishes reducing first.
- R4: Every set produces exactly one out_valid_o cycle. No adder result is ever lost.
- R5: An element is taken only in a cycle with in_valid_i and in_ready_o both high. in_ready_o drops when fewer than two buffer entries are free. It also drops when all SET_SLOTS tracking slots are occupied and the next element would open a new set.
- R6: After reset, out_valid_o is low and in_ready_o is high.
- R7: The first element of a new set can be accepted before the total of the previous set has been emitted.
- R8: The adder only ever combines two operands that belong to the same set.
- R9: An accepted element with in_last_i high closes its set. The next accepted element starts a new set and takes its identifier from in_id_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input element is valid |
| in_ready_o | output | 1 | Unit can take an element this cycle |
| in_data_i | input | DATA_W | Element value |
| in_id_i | input | ID_W | Set identifier, sampled on the set's first element |
| in_last_i | input | 1 | Element is the final one of its set |
| out_valid_o | output | 1 | A set total is presented this cycle |
| out_id_o | output | ID_W | Identifier of the emitted set |
| out_sum_o | output | DATA_W | Total of the emitted set |

## Verification
The bench builds the unit with a 16-bit datapath, a three-stage adder, six buffer entries and four tracking slots. This configuration is small enough that a sweep over every pair of set lengths from one to five, with zero to two idle cycles between elements, covers all the ways the input, buffered values and adder results can collide in the scheduler. With only four slots, a long set followed by a burst of one-element sets fills the slot table. That forces in_ready_o low and makes the one-element totals wait behind an older, unfinished set. The values are chosen so that sums wrap past 2^16.

// File: rtl/sr_pkg.sv
package sr_pkg;
  // adder operand selection, highest priority first
  typedef enum logic [2:0] {
    PICK_NONE,
    PICK_OUT_BUF,
    PICK_BUF_BUF,
    PICK_IN_BUF,
    PICK_IN_OUT
  } pick_e;
endpackage

// File: rtl/sr_add_pipe.sv
module sr_add_pipe #(
  parameter int W   = 16,
  parameter int SW  = 2,
  parameter int LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          v_i,
  input  logic [SW-1:0] slot_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic          v_o,
  output logic [SW-1:0] slot_o,
  output logic [W-1:0]  sum_o
);
  logic [LAT-1:0]         v_q;
  logic [LAT-1:0][SW-1:0] s_q;
  logic [LAT-1:0][W-1:0]  d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      s_q <= '0;
      d_q <= '0;
    end else begin
      v_q[0] <= v_i;
      s_q[0] <= slot_i;
      d_q[0] <= a_i + b_i;
      for (int k = 1; k < LAT; k++) begin
        v_q[k] <= v_q[k-1];
        s_q[k] <= s_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  end

  assign v_o    = v_q[LAT-1];
  assign slot_o = s_q[LAT-1];
  assign sum_o  = d_q[LAT-1];
endmodule

// File: rtl/sr_slot_match.sv
module sr_slot_match #(
  parameter int N  = 6,
  parameter int SW = 2,
  parameter int IW = 3
) (
  input  logic [N-1:0]         v_i,
  input  logic [N-1:0][SW-1:0] slot_i,
  input  logic                 probe_v_i,
  input  logic [SW-1:0]        probe_slot_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit_o && probe_v_i && v_i[i] && slot_i[i] == probe_slot_i) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sr_pair_find.sv
module sr_pair_find #(
  parameter int N  = 6,
  parameter int SW = 2,
  parameter int IW = 3
) (
  input  logic [N-1:0]         v_i,
  input  logic [N-1:0][SW-1:0] slot_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_a_o,
  output logic [IW-1:0]        idx_b_o
);
  always_comb begin
    hit_o   = 1'b0;
    idx_a_o = '0;
    idx_b_o = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (!hit_o && v_i[i] && v_i[j] && slot_i[i] == slot_i[j]) begin
          hit_o   = 1'b1;
          idx_a_o = IW'(i);
          idx_b_o = IW'(j);
        end
      end
    end
  end
endmodule

// File: rtl/sr_free_pick.sv
module sr_free_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  free_i,
  output logic          has0_o,
  output logic          has1_o,
  output logic [IW-1:0] idx0_o,
  output logic [IW-1:0] idx1_o
);
  always_comb begin
    has0_o = 1'b0;
    has1_o = 1'b0;
    idx0_o = '0;
    idx1_o = '0;
    for (int i = 0; i < N; i++) begin
      if (free_i[i]) begin
        if (!has0_o) begin
          has0_o = 1'b1;
          idx0_o = IW'(i);
        end else if (!has1_o) begin
          has1_o = 1'b1;
          idx1_o = IW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/streamsum_reducer.sv
module streamsum_reducer
  import sr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ID_W      = 4,
  parameter int ADD_LAT   = 3,
  parameter int BUF_DEPTH = 6,  // keep >= SET_SLOTS + 2
  parameter int SET_SLOTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [ID_W-1:0]   in_id_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  output logic [ID_W-1:0]   out_id_o,
  output logic [DATA_W-1:0] out_sum_o
);
  localparam int SLOT_W = $clog2(SET_SLOTS);
  localparam int IDX_W  = $clog2(BUF_DEPTH);
  localparam int LIVE_W = $clog2(BUF_DEPTH + ADD_LAT + 4) + 1;
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1);

  // operand buffer
  logic [BUF_DEPTH-1:0]             buf_v_q;
  logic [BUF_DEPTH-1:0][SLOT_W-1:0] buf_slot_q;
  logic [BUF_DEPTH-1:0][DATA_W-1:0] buf_val_q;

  // per-set tracking slots
  logic [LIVE_W-1:0] slot_live_q [SET_SLOTS];
  logic [SET_SLOTS-1:0] slot_last_q, slot_done_q;
  logic [DATA_W-1:0] slot_sum_q  [SET_SLOTS];
  logic [ID_W-1:0]   slot_id_q   [SET_SLOTS];
  logic [SLOT_W-1:0] head_q, tail_q, cur_slot_q;
  logic [SLOT_W:0]   slot_cnt_q;
  logic              open_q;

  // adder pipe
  logic              po_v;
  logic [SLOT_W-1:0] po_slot;
  logic [DATA_W-1:0] po_sum;

  logic              accept, in_first, in_single, in_avail;
  logic [SLOT_W-1:0] in_slot;
  logic              po_done, po_avail, po_taken;
  logic [CNT_W-1:0]  free_cnt;
  logic              emit;

  logic              om_hit, im_hit, pf_hit, io_hit;
  logic [IDX_W-1:0]  om_idx, im_idx, pf_a, pf_b;
  pick_e             pick;
  logic              issue_v;
  logic [SLOT_W-1:0] opa_slot, opb_slot;
  logic [DATA_W-1:0] opa, opb;
  logic [BUF_DEPTH-1:0] consumed;
  logic              out_to_buf, in_to_buf, wr_room;
  logic              fh0, fh1;
  logic [IDX_W-1:0]  fi0, fi1, widx_out, widx_in;

  // input side
  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < BUF_DEPTH; i++) free_cnt = free_cnt + CNT_W'(!buf_v_q[i]);
  end

  assign in_ready_o = (free_cnt >= CNT_W'(2)) &&
                      (open_q || slot_cnt_q < (SLOT_W+1)'(SET_SLOTS));
  assign accept    = in_valid_i && in_ready_o;
  assign in_first  = !open_q;
  assign in_slot   = open_q ? cur_slot_q : tail_q;
  assign in_single = in_first && in_last_i;
  assign in_avail  = accept && !in_single;

  // adder result: final total when its set is closed and it is the only live operand
  assign po_done  = po_v && slot_last_q[po_slot] && (slot_live_q[po_slot] == LIVE_W'(1));
  assign po_avail = po_v && !po_done;

  sr_slot_match #(.N(BUF_DEPTH), .SW(SLOT_W), .IW(IDX_W)) u_match_out (
    .v_i(buf_v_q), .slot_i(buf_slot_q), .probe_v_i(po_avail), .probe_slot_i(po_slot),
    .hit_o(om_hit), .idx_o(om_idx));

  sr_slot_match #(.N(BUF_DEPTH), .SW(SLOT_W), .IW(IDX_W)) u_match_in (
    .v_i(buf_v_q), .slot_i(buf_slot_q), .probe_v_i(in_avail), .probe_slot_i(in_slot),
    .hit_o(im_hit), .idx_o(im_idx));

  sr_pair_find #(.N(BUF_DEPTH), .SW(SLOT_W), .IW(IDX_W)) u_pair (
    .v_i(buf_v_q), .slot_i(buf_slot_q), .hit_o(pf_hit), .idx_a_o(pf_a), .idx_b_o(pf_b));

  assign io_hit = in_avail && po_avail && (in_slot == po_slot);

  // operand scheduling
  always_comb begin
    pick     = PICK_NONE;
    opa      = '0;
    opb      = '0;
    opa_slot = '0;
    opb_slot = '0;
    consumed = '0;
    if (om_hit)      pick = PICK_OUT_BUF;
    else if (pf_hit) pick = PICK_BUF_BUF;
    else if (im_hit) pick = PICK_IN_BUF;
    else if (io_hit) pick = PICK_IN_OUT;
    case (pick)
      PICK_OUT_BUF: begin
        opa = po_sum;             opa_slot = po_slot;
        opb = buf_val_q[om_idx];  opb_slot = buf_slot_q[om_idx];
        consumed[om_idx] = 1'b1;
      end
      PICK_BUF_BUF: begin
        opa = buf_val_q[pf_a];    opa_slot = buf_slot_q[pf_a];
        opb = buf_val_q[pf_b];    opb_slot = buf_slot_q[pf_b];
        consumed[pf_a] = 1'b1;
        consumed[pf_b] = 1'b1;
      end
      PICK_IN_BUF: begin
        opa = in_data_i;          opa_slot = in_slot;
        opb = buf_val_q[im_idx];  opb_slot = buf_slot_q[im_idx];
        consumed[im_idx] = 1'b1;
      end
      PICK_IN_OUT: begin
        opa = in_data_i;          opa_slot = in_slot;
        opb = po_sum;             opb_slot = po_slot;
      end
      default: ;
    endcase
  end

  assign issue_v = (pick != PICK_NONE);

  sr_add_pipe #(.W(DATA_W), .SW(SLOT_W), .LAT(ADD_LAT)) u_add (
    .clk_i, .rst_ni, .v_i(issue_v), .slot_i(opa_slot), .a_i(opa), .b_i(opb),
    .v_o(po_v), .slot_o(po_slot), .sum_o(po_sum));

  // leftovers go to the buffer, into entries free now or freed this cycle
  assign out_to_buf = po_avail && pick != PICK_OUT_BUF && pick != PICK_IN_OUT;
  assign in_to_buf  = in_avail && pick != PICK_IN_BUF && pick != PICK_IN_OUT;

  sr_free_pick #(.N(BUF_DEPTH), .IW(IDX_W)) u_free (
    .free_i(~buf_v_q | consumed), .has0_o(fh0), .has1_o(fh1), .idx0_o(fi0), .idx1_o(fi1));

  assign widx_out = fi0;
  assign widx_in  = out_to_buf ? fi1 : fi0;
  assign wr_room  = out_to_buf ? (fh0 && (!in_to_buf || fh1)) : (!in_to_buf || fh0);
  assign po_taken = !po_v || po_done || pick == PICK_OUT_BUF || pick == PICK_IN_OUT ||
                    (out_to_buf && fh0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_v_q    <= '0;
      buf_slot_q <= '0;
      buf_val_q  <= '0;
    end else begin
      for (int i = 0; i < BUF_DEPTH; i++) begin
        if (consumed[i]) buf_v_q[i] <= 1'b0;
        if (out_to_buf && widx_out == IDX_W'(i)) begin
          buf_v_q[i]    <= 1'b1;
          buf_slot_q[i] <= po_slot;
          buf_val_q[i]  <= po_sum;
        end
        if (in_to_buf && widx_in == IDX_W'(i)) begin
          buf_v_q[i]    <= 1'b1;
          buf_slot_q[i] <= in_slot;
          buf_val_q[i]  <= in_data_i;
        end
      end
    end
  end

  // slot table and in-order release
  assign emit        = slot_done_q[head_q];
  assign out_valid_o = emit;
  assign out_id_o    = slot_id_q[head_q];
  assign out_sum_o   = slot_sum_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SET_SLOTS; s++) begin
        slot_live_q[s] <= '0;
        slot_sum_q[s]  <= '0;
        slot_id_q[s]   <= '0;
      end
      slot_last_q <= '0;
      slot_done_q <= '0;
      head_q      <= '0;
      tail_q      <= '0;
      cur_slot_q  <= '0;
      slot_cnt_q  <= '0;
      open_q      <= 1'b0;
    end else begin
      for (int s = 0; s < SET_SLOTS; s++) begin
        if (po_done && po_slot == SLOT_W'(s)) begin
          slot_live_q[s] <= '0;
          slot_done_q[s] <= 1'b1;
          slot_sum_q[s]  <= po_sum;
        end else begin
          slot_live_q[s] <= slot_live_q[s]
                          + LIVE_W'(in_avail && in_slot == SLOT_W'(s))
                          - LIVE_W'(issue_v && opa_slot == SLOT_W'(s));
        end
        if (emit && head_q == SLOT_W'(s)) begin
          slot_done_q[s] <= 1'b0;
          slot_last_q[s] <= 1'b0;
        end
        if (accept && in_slot == SLOT_W'(s)) begin
          if (in_first)  slot_id_q[s]   <= in_id_i;
          if (in_last_i) slot_last_q[s] <= 1'b1;
          if (in_single) begin
            slot_done_q[s] <= 1'b1;
            slot_sum_q[s]  <= in_data_i;
          end
        end
      end
      if (accept) begin
        open_q     <= !in_last_i;
        cur_slot_q <= in_slot;
      end
      if (accept && in_first)
        tail_q <= (tail_q == SLOT_W'(SET_SLOTS - 1)) ? '0 : tail_q + 1'b1;
      if (emit)
        head_q <= (head_q == SLOT_W'(SET_SLOTS - 1)) ? '0 : head_q + 1'b1;
      slot_cnt_q <= slot_cnt_q + (SLOT_W+1)'(accept && in_first) - (SLOT_W+1)'(emit);
    end
  end
endmodule

// File: rtl/streamsum_reducer_chk.sv
module streamsum_reducer_chk #(
  parameter int SLOT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_last_i,
  input logic              out_valid_o,
  input logic              issue_v,
  input logic [SLOT_W-1:0] opa_slot,
  input logic [SLOT_W-1:0] opb_slot,
  input logic [SLOT_W-1:0] head_q,
  input logic              po_taken,
  input logic              out_to_buf,
  input logic              in_to_buf,
  input logic              wr_room,
  input logic              open_q
);
  // R8
  same_set_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_v |-> opa_slot == opb_slot);

  // R4
  pipe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    po_taken);

  // R5
  buf_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_to_buf || in_to_buf) |-> wr_room);

  // R3
  head_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> head_q != $past(head_q));

  // R9
  set_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) |=> !open_q);
endmodule

bind streamsum_reducer streamsum_reducer_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .in_last_i  (in_last_i),
  .out_valid_o(out_valid_o),
  .issue_v    (issue_v),
  .opa_slot   (opa_slot),
  .opb_slot   (opb_slot),
  .head_q     (head_q),
  .po_taken   (po_taken),
  .out_to_buf (out_to_buf),
  .in_to_buf  (in_to_buf),
  .wr_room    (wr_room),
  .open_q     (open_q)
);

// File: tb/streamsum_reducer_tb.sv
module streamsum_reducer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int IW = 4;
  localparam int MAXS = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [IW-1:0] in_id = '0;
  logic in_ready, out_valid;
  logic [IW-1:0] out_id;
  logic [DW-1:0] out_sum;

  always #(CLK_PERIOD/2) clk = ~clk;

  streamsum_reducer #(.DATA_W(DW), .ID_W(IW), .ADD_LAT(3), .BUF_DEPTH(6), .SET_SLOTS(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_id_i(in_id), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_id_o(out_id), .out_sum_o(out_sum));

  int checks = 0, failures = 0;
  logic [IW-1:0] exp_id [MAXS];
  logic [DW-1:0] exp_sum[MAXS];
  int            exp_len[MAXS];
  int  wr = 0, rd = 0;
  int  overlaps = 0;
  bit  stall_seen = 1'b0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compare each emitted total with the expected queue
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd >= wr) begin
        chk(1'b0, "R4 extra total", rd, wr);
      end else begin
        chk(out_id == exp_id[rd], "R3 set order/id", out_id, exp_id[rd]);
        if (exp_len[rd] == 1)
          chk(out_sum == exp_sum[rd], "R2 single-element total", out_sum, exp_sum[rd]);
        else
          chk(out_sum == exp_sum[rd], "R1 R8 set total", out_sum, exp_sum[rd]);
        rd++;
      end
    end
  end

  task automatic push(input logic [IW-1:0] id, input logic [DW-1:0] d, input logic last,
                      input bit first);
    in_valid = 1'b1; in_id = id; in_data = d; in_last = last;
    while (!in_ready) begin
      stall_seen = 1'b1;
      @(negedge clk);
    end
    if (first && rd < wr - 1) overlaps++;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_set(input int len, input int gap);
    logic [DW-1:0] acc = '0;
    int n = wr;
    exp_id[n]  = IW'(n % 16);
    exp_len[n] = len;
    for (int k = 0; k < len; k++) acc = acc + DW'(n * 4099 + k * 613 + 7);
    exp_sum[n] = acc;
    wr++;
    for (int k = 0; k < len; k++) begin
      push(IW'(n % 16), DW'(n * 4099 + k * 613 + 7), k == len - 1, k == 0);
      if (k != len - 1) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (rd < wr && t < 300) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(out_valid == 1'b0, "R6 out_valid after reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R6 no output when idle", out_valid, 0);

    // sweep over pairs of set lengths and element spacing
    for (int la = 1; la <= 5; la++)
      for (int lb = 1; lb <= 5; lb++)
        for (int g = 0; g <= 2; g++) begin
          send_set(la, g);
          send_set(lb, 0);
        end
    drain();
    chk(rd == wr, "R4 sweep totals count", rd, wr);
    // R7: back-to-back sets start while an earlier total is pending
    chk(overlaps > 0, "R7 set overlap observed", overlaps, 1);

    // slot-table pressure: long set then a burst of single-element sets
    send_set(12, 0);
    for (int s = 0; s < 6; s++) send_set(1, 0);
    drain();
    chk(stall_seen, "R5 ready dropped under pressure", stall_seen, 1);
    chk(rd == wr, "R4 R9 totals after pressure", rd, wr);

    // idle sweep: nothing emitted with no input
    repeat (20) @(negedge clk);
    chk(rd == wr && !out_valid, "R4 quiet when idle", rd, wr);
    chk(in_ready == 1'b1, "R5 ready restored", in_ready, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", rd, wr);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule